// File: doc/BRIEF.md
# Low-Power Mode Entry and Wake Sequencer

The sequencer parks a small processor system in one of two sleep depths and brings it back. In the light depth, deep-sleep, the main oscillator is shut off and clocks stop. The internal RC oscillator keeps running and the flash sits in standby, so it stays usable. In the deep depth, power-down, the RC oscillator also stops and the flash loses power. Entering either depth disconnects the PLLs and resets the clock dividers. A status flag for each depth is set on entry and stays set until software clears it.

Wake-up begins on any enabled wake source. The watchdog source does not count in power-down, because its clock is stopped there. The CPU clock returns after a stabilisation wait that depends on the clock source in use before sleep and on the depth. Waking from power-down also starts a separate flash timer. The CPU can run from SRAM before the flash becomes accessible again. Every analog delay is expressed as a count of cycles of the always-on reference clock.

Top module: `lp_mode_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in run (`mode` = 00). `cpu_clk_en`, `flash_ready`, `osc_en` and `irc_en` are high, `pll_disconnect` and `div_reset` are low, and both flags are clear. A reset during any sleep or wake phase returns the block to this state.
- R2: A `sleep_req` sampled in run with `sleep_pd`=0 enters deep-sleep (`mode` = 01) at the next edge. There `cpu_clk_en` and `osc_en` are low, `irc_en` stays high, `flash_ready` stays high, `pll_disconnect` and `div_reset` are high, and `ds_flag` is set.
- R3: A `sleep_req` sampled in run with `sleep_pd`=1 enters power-down (`mode` = 10). There `irc_en` is also low, `flash_ready` is low, and `pd_flag` is set.
- R4: Wake starts only from a `wake_src` bit whose `wake_en` bit is high. In power-down, bit `WDT_IDX` (the watchdog, default 10) is ignored. In deep-sleep it wakes the block.
- R5: After a wake from deep-sleep with the RC oscillator as source (`src_osc`=0 at entry), `mode` = 11 (waking) lasts exactly `IRC_CNT` cycles. Then the block returns to run and `cpu_clk_en` rises.
- R6: With the main oscillator as source (`src_osc`=1 at entry), waking lasts exactly `OSC_CNT` cycles from either depth. `osc_en` is high throughout.
- R7: After a wake from power-down with the RC oscillator as source, waking lasts `IRC_START`+`IRC_CNT` cycles.
- R8: After power-down, `flash_ready` rises exactly `FLASH_WAKE` cycles after waking begins, whether that is before or after `cpu_clk_en` returns.
- R9: A wake arriving in the same cycle as the accepted `sleep_req` is kept. The block spends one cycle in the sleep mode and then enters waking.
- R10: `flag_clr` bit 0 clears `ds_flag` and bit 1 clears `pd_flag`. Otherwise the flags persist through wake and run.
- R11: `sleep_req` is ignored outside run, and also in run while `flash_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter a sleep depth |
| sleep_pd | input | 1 | Depth select: 0 deep-sleep, 1 power-down |
| src_osc | input | 1 | CPU clock source: 1 main oscillator, 0 RC oscillator |
| wake_src | input | NWAKE | Wake request per source |
| wake_en | input | NWAKE | Enable per wake source |
| flag_clr | input | 2 | Write-one-to-clear for the flags (bit 0 deep-sleep, bit 1 power-down) |
| cpu_clk_en | output | 1 | CPU and peripheral clock release |
| flash_ready | output | 1 | Flash access allowed |
| osc_en | output | 1 | Main oscillator enable |
| irc_en | output | 1 | RC oscillator enable |
| pll_disconnect | output | 1 | PLLs off and disconnected |
| div_reset | output | 1 | Clock dividers held at zero |
| mode | output | 2 | 00 run, 01 deep-sleep, 10 power-down, 11 waking |
| ds_flag | output | 1 | Deep-sleep entered since last clear |
| pd_flag | output | 1 | Power-down entered since last clear |

## Verification
The bench builds the block with `IRC_CNT`=4, `IRC_START`=10, `OSC_CNT`=40 and `FLASH_WAKE`=25. With these values both orderings of CPU release and flash readiness occur within a few dozen cycles. From power-down on the RC oscillator, the CPU resumes at 14 cycles and the flash follows at 25. On the main oscillator, the flash is ready at 25 and the CPU waits until 40. The flash-busy window that blocks a new sleep request can then be probed while the CPU is already running.

// File: rtl/lp_mode_seq.sv
module lp_mode_seq #(
  parameter int NWAKE      = 11,
  parameter int WDT_IDX    = 10,
  parameter int IRC_CNT    = 4,
  parameter int OSC_CNT    = 4096,
  parameter int IRC_START  = 60,
  parameter int FLASH_WAKE = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             sleep_pd,
  input  logic             src_osc,
  input  logic [NWAKE-1:0] wake_src,
  input  logic [NWAKE-1:0] wake_en,
  input  logic [1:0]       flag_clr,
  output logic             cpu_clk_en,
  output logic             flash_ready,
  output logic             osc_en,
  output logic             irc_en,
  output logic             pll_disconnect,
  output logic             div_reset,
  output logic [1:0]       mode,
  output logic             ds_flag,
  output logic             pd_flag
);
  localparam int IRC_PD = IRC_START + IRC_CNT;
  localparam int MAX_A  = (OSC_CNT > IRC_PD) ? OSC_CNT : IRC_PD;
  localparam int MAXC   = (MAX_A > FLASH_WAKE) ? MAX_A : FLASH_WAKE;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [1:0] M_RUN = 2'd0, M_DS = 2'd1, M_PD = 2'd2, M_WAKE = 2'd3;

  logic [1:0]    mode_q;
  logic          pd_q, src_osc_q, pend_q, fbusy_q;
  logic [CW-1:0] cnt_q, fcnt_q;

  wire sleeping = (mode_q == M_DS) || (mode_q == M_PD);
  wire in_pd    = (mode_q == M_PD) || ((mode_q == M_RUN) && sleep_pd);
  wire [NWAKE-1:0] wdt_bit = NWAKE'(1) << WDT_IDX;
  wire wake_hit = |(wake_src & wake_en & ~(in_pd ? wdt_bit : '0));
  wire go = (mode_q == M_RUN) && sleep_req && !fbusy_q;
  wire [CW-1:0] wake_len = src_osc_q ? CW'(OSC_CNT - 1) :
                           pd_q      ? CW'(IRC_PD - 1)  : CW'(IRC_CNT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_RUN;
      pd_q      <= 1'b0;
      src_osc_q <= 1'b0;
      pend_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      case (mode_q)
        M_RUN: if (go) begin
          mode_q    <= sleep_pd ? M_PD : M_DS;
          pd_q      <= sleep_pd;
          src_osc_q <= src_osc;
          pend_q    <= wake_hit;
        end
        M_DS, M_PD: if (wake_hit || pend_q) begin
          mode_q <= M_WAKE;
          pend_q <= 1'b0;
          cnt_q  <= wake_len;
        end
        default: begin
          if (cnt_q == '0) mode_q <= M_RUN;
          else cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbusy_q <= 1'b0;
      fcnt_q  <= '0;
    end else if (go && sleep_pd) begin
      fbusy_q <= 1'b1;
      fcnt_q  <= CW'(FLASH_WAKE);
    end else if (fbusy_q && !sleeping) begin
      fcnt_q <= fcnt_q - 1'b1;
      if (fcnt_q == CW'(1)) fbusy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_flag <= 1'b0;
      pd_flag <= 1'b0;
    end else begin
      ds_flag <= (ds_flag & ~flag_clr[0]) | (go & ~sleep_pd);
      pd_flag <= (pd_flag & ~flag_clr[1]) | (go & sleep_pd);
    end
  end

  assign mode           = mode_q;
  assign cpu_clk_en     = (mode_q == M_RUN);
  assign flash_ready    = !fbusy_q;
  assign osc_en         = (mode_q == M_RUN) || ((mode_q == M_WAKE) && src_osc_q);
  assign irc_en         = (mode_q == M_RUN) || (mode_q == M_DS) ||
                          ((mode_q == M_WAKE) && (!src_osc_q || !pd_q));
  assign pll_disconnect = (mode_q != M_RUN);
  assign div_reset      = (mode_q != M_RUN);

  a_r2_ds_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_RUN && mode_q == M_DS) |-> ds_flag && flash_ready && irc_en && !osc_en);
  a_r3_pd_flash_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PD) |-> !flash_ready && !irc_en && pd_flag);
  a_r4_wdt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PD && !pend_q && (wake_src & wake_en) == wdt_bit) |=> mode_q == M_PD);
  a_r5_release_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(mode_q) == M_WAKE);
  a_r8_flash_drop_on_pd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_ready) |-> mode_q == M_PD);
  a_r9_pending_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && pend_q) |=> mode_q == M_WAKE);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_flag && !flag_clr[0]) |=> ds_flag);
  a_r11_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && !flash_ready) |=> mode_q == M_RUN);
endmodule

// File: tb/tb_lp_mode_seq.sv
`timescale 1ns/1ps
module tb_lp_mode_seq;
  localparam int NW = 11, WDT = 10, IC = 4, OC = 40, IS = 10, FW = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, sleep_pd = 0, src_osc = 0;
  logic [NW-1:0] wake_src = '0, wake_en = '0;
  logic [1:0] flag_clr = '0;
  logic cpu_clk_en, flash_ready, osc_en, irc_en, pll_disconnect, div_reset, ds_flag, pd_flag;
  logic [1:0] mode;

  int tests = 0, fails = 0;
  int m_mode, m_left, m_fleft;
  bit m_pd, m_src, m_pend, m_ds_f, m_pd_f;

  always #4 clk = ~clk;

  lp_mode_seq #(.NWAKE(NW), .WDT_IDX(WDT), .IRC_CNT(IC), .OSC_CNT(OC),
                .IRC_START(IS), .FLASH_WAKE(FW)) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_pd(sleep_pd),
    .src_osc(src_osc), .wake_src(wake_src), .wake_en(wake_en), .flag_clr(flag_clr),
    .cpu_clk_en(cpu_clk_en), .flash_ready(flash_ready), .osc_en(osc_en), .irc_en(irc_en),
    .pll_disconnect(pll_disconnect), .div_reset(div_reset), .mode(mode),
    .ds_flag(ds_flag), .pd_flag(pd_flag));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_fleft = 0; m_pd = 0; m_src = 0; m_pend = 0;
      m_ds_f = 0; m_pd_f = 0;
    end else begin
      bit inpd, hit, acc, slp;
      logic [NW-1:0] msk;
      inpd = (m_mode == 2) || (m_mode == 0 && sleep_pd);
      msk = inpd ? ~(NW'(1) << WDT) : '1;
      hit = |(wake_src & wake_en & msk);
      acc = (m_mode == 0) && sleep_req && (m_fleft == 0);
      slp = (m_mode == 1) || (m_mode == 2);
      if (m_fleft > 0 && !slp) m_fleft--;
      m_ds_f = (m_ds_f && !flag_clr[0]) || (acc && !sleep_pd);
      m_pd_f = (m_pd_f && !flag_clr[1]) || (acc && sleep_pd);
      if (m_mode == 0) begin
        if (acc) begin
          m_mode = sleep_pd ? 2 : 1; m_pd = sleep_pd; m_src = src_osc; m_pend = hit;
          if (sleep_pd) m_fleft = FW;
        end
      end else if (slp) begin
        if (hit || m_pend) begin
          m_mode = 3; m_pend = 0;
          m_left = m_src ? OC : (m_pd ? IS + IC : IC);
        end
      end else begin
        m_left--;
        if (m_left == 0) m_mode = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(int'(mode) == m_mode, "R9 mode", mode, m_mode);
    chk(cpu_clk_en == (m_mode == 0), "R5 cpu_clk_en", cpu_clk_en, m_mode == 0);
    chk(flash_ready == (m_fleft == 0), "R8 flash_ready", flash_ready, m_fleft == 0);
    chk(osc_en == (m_mode == 0 || (m_mode == 3 && m_src)), "R6 osc_en", osc_en,
        m_mode == 0 || (m_mode == 3 && m_src));
    chk(irc_en == (m_mode == 0 || m_mode == 1 || (m_mode == 3 && (!m_src || !m_pd))),
        "R3 irc_en", irc_en, m_mode == 0 || m_mode == 1 || (m_mode == 3 && (!m_src || !m_pd)));
    chk(pll_disconnect == (m_mode != 0) && div_reset == (m_mode != 0), "R2 pll/div",
        pll_disconnect, m_mode != 0);
    chk(ds_flag == m_ds_f && pd_flag == m_pd_f, "R10 flags", {ds_flag, pd_flag}, {m_ds_f, m_pd_f});
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(input bit pd, input bit osc);
    sleep_pd = pd; src_osc = osc; sleep_req = 1; step(); sleep_req = 0;
  endtask

  task automatic wake(input int bitn);
    wake_src = NW'(1) << bitn; step(); wake_src = '0;
  endtask

  task automatic measure(output int nc, output int nf);
    nc = 0; nf = 0;
    while (!(cpu_clk_en && flash_ready)) begin
      if (!cpu_clk_en) nc++;
      if (!flash_ready) nf++;
      step();
    end
  endtask

  initial begin
    int nc, nf;
    step(2); rst_n = 1; step();
    chk(mode == 2'b00 && cpu_clk_en && flash_ready && osc_en && irc_en && !pll_disconnect
        && !div_reset && !ds_flag && !pd_flag, "R1 reset state", mode, 0);

    wake_en = '1 ^ (NW'(1) << 3);
    enter(0, 0);
    chk(mode == 2'b01 && ds_flag && irc_en && !osc_en && flash_ready, "R2 deep-sleep entry", mode, 1);
    wake(3); step(2);
    chk(mode == 2'b01, "R4 disabled source ignored", mode, 1);
    sleep_req = 1; step(); sleep_req = 0;
    chk(mode == 2'b01, "R11 request while asleep", mode, 1);
    wake(0); measure(nc, nf);
    chk(nc == IC, "R5 deep-sleep RC wake length", nc, IC);
    chk(ds_flag, "R10 flag persists", ds_flag, 1);
    flag_clr = 2'b01; step(); flag_clr = '0;
    chk(!ds_flag, "R10 clear deep-sleep flag", ds_flag, 0);

    enter(0, 0); wake(WDT); measure(nc, nf);
    chk(nc == IC, "R4 watchdog wakes deep-sleep", nc, IC);

    enter(1, 0);
    chk(mode == 2'b10 && !flash_ready && !irc_en && pd_flag, "R3 power-down entry", mode, 2);
    wake(WDT); step(2);
    chk(mode == 2'b10, "R4 watchdog ignored in power-down", mode, 2);
    wake(5); nc = 0;
    while (!cpu_clk_en) begin nc++; step(); end
    chk(nc == IS + IC, "R7 power-down RC wake length", nc, IS + IC);
    chk(!flash_ready, "R8 CPU runs before flash", flash_ready, 0);
    sleep_req = 1; sleep_pd = 0; step(); sleep_req = 0;
    chk(mode == 2'b00, "R11 request while flash busy", mode, 0);
    nf = nc + 1;
    while (!flash_ready) begin nf++; step(); end
    chk(nf == FW, "R8 flash wake length", nf, FW);

    enter(1, 1); wake(1); measure(nc, nf);
    chk(nc == OC, "R6 oscillator wake length", nc, OC);
    chk(nf == FW, "R8 flash before CPU", nf, FW);
    flag_clr = 2'b10; step(); flag_clr = '0;
    chk(!pd_flag, "R10 clear power-down flag", pd_flag, 0);

    sleep_pd = 0; src_osc = 0; sleep_req = 1; wake_src = NW'(1) << 2; step();
    sleep_req = 0; wake_src = '0;
    chk(mode == 2'b01, "R9 entry completes", mode, 1);
    step();
    chk(mode == 2'b11, "R9 pending wake kept", mode, 3);
    measure(nc, nf);

    enter(1, 1); wake(0); step(3);
    rst_n = 0; step(); rst_n = 1; step();
    chk(mode == 2'b00 && cpu_clk_en && flash_ready && osc_en && irc_en && !pd_flag,
        "R1 reset aborts wake", mode, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule